// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block sits at the core of a cascade-capable interrupt controller. It resolves eight level-sensitive request lines and tracks which of them are in service. Each clock it samples the request lines into a pending register and removes the inputs whose mask bits are set. It then compares the highest-priority remaining request against the highest-priority input already in service. The interrupt output to the processor stays high while a request wins that comparison.

When the processor acknowledges, the block marks the winning input as in service and clears its pending bit for one cycle. A non-specific end-of-interrupt command retires the highest-priority in-service input. Software reads the in-service register to find out whether any service is still open. Priority is fixed, with input 0 highest.

Two nesting policies are available. In normal nesting, an in-service input blocks itself and every input below it. Special nesting is meant for a master whose inputs are fed by slave controllers. In that policy, an in-service input may interrupt again, so a more urgent request inside a slave still reaches the processor. An automatic end-of-interrupt option makes an acknowledge leave the in-service register untouched.

Top module: `irq_nest_resolver`

## Requirements
- R1: Reset clears the in-service register, the mask register and the pending register. After reset, int_o is low, and any single request reaches int_o.
- R2: A request level is sampled on the clock edge, and int_o rises in the cycle after the edge that samples it. If the request is not acknowledged, int_o falls in the cycle after the edge that samples it low.
- R3: Mask bit i set to 1 removes input i from arbitration. A mask write takes effect from the cycle after its edge. When every mask bit is 1, int_o stays low.
- R4: Bit i of every vector is input i. Input 0 has the highest priority and input 7 the lowest. While int_o is high, ack_id_o gives the lowest index among the pending, unmasked requests.
- R5: If ack_i is high while int_o is high, ack_valid_o is high in that cycle. At the next edge, in-service bit ack_id_o is set and that input's pending bit is cleared. The pending bit is sampled again from the request line at the following edge.
- R6: In normal nesting (sfn_en_i = 0), a set in-service bit keeps int_o low for requests on the same input and on every lower-priority input.
- R7: In special nesting (sfn_en_i = 1), a request on the input that is the highest-priority in-service bit raises int_o again. Requests on lower-priority inputs stay blocked.
- R8: If eoi_i is high at an edge, that edge clears only the lowest-index set bit of the in-service register. If the register is all zeros, it stays all zeros.
- R9: With aeoi_en_i = 1, an acknowledge leaves the in-service register unchanged.
- R10: An ack_i while int_o is low has no effect on the in-service register, and ack_valid_o stays low.
- R11: If ack_i and eoi_i are both high in a cycle where int_o is high, the end-of-interrupt acts first and clears the old highest in-service bit. The winner's bit is then set.
- R12: In both nesting policies, a request whose priority is higher than every in-service bit raises int_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Level-sensitive request lines, bit i is input i |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 8 | New mask value, 1 disables the input |
| sfn_en_i | input | 1 | 1 selects special nesting |
| aeoi_en_i | input | 1 | 1 selects automatic end-of-interrupt |
| ack_i | input | 1 | First acknowledge pulse from the processor |
| eoi_i | input | 1 | Non-specific end-of-interrupt command strobe |
| int_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | High while an acknowledge is accepted |
| ack_id_o | output | 3 | Index of the winning request |
| isr_o | output | 8 | In-service register |

## Verification
Several properties are checked on every cycle. The nesting rule must hold under both policies: no in-service bit is at or above the winner in normal nesting, and none is strictly above it in special nesting. An accepted acknowledge must set the winner's bit unless automatic end-of-interrupt is on. An end-of-interrupt must retire exactly one bit. An ignored acknowledge must leave the register untouched.

Other behaviour can only be shown by the bench's scenarios. These scenarios cover the one-cycle request latency, the effect of every mask value on priority, and the exact order in which stacked services retire. They also cover a same-cycle acknowledge with end-of-interrupt, and the full sweep of in-service input against requesting input under both policies.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // Lowest set index of the first n bits of v, or n if none is set.
  function automatic int first_set(input logic [31:0] v, input int n);
    int r;
    r = n;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Ones at every index strictly below idx.
  function automatic logic [31:0] below_mask(input int idx);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < idx) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_IN = 8,
  localparam int IDX_W = $clog2(NUM_IN + 1)
) (
  input  logic [NUM_IN-1:0] vec_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_IN-1:0] onehot_o
);
  import irq_nest_pkg::*;

  int sel;

  always_comb begin
    sel   = first_set(32'(vec_i), NUM_IN);
    any_o = (sel != NUM_IN);
    idx_o = IDX_W'(sel);
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_oh
    assign onehot_o[g] = (sel == g);
  end
endmodule

// File: rtl/irq_req_stage.sv
module irq_req_stage #(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req_i,
  input  logic              clr_en_i,
  input  logic [NUM_IN-1:0] clr_oh_i,
  input  logic              mask_we_i,
  input  logic [NUM_IN-1:0] mask_wdata_i,
  output logic [NUM_IN-1:0] irr_q,
  output logic [NUM_IN-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      mask_q <= '0;
    end else begin
      irr_q <= req_i & ~(clr_en_i ? clr_oh_i : '0);
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end
endmodule

// File: rtl/irq_isr_reg.sv
module irq_isr_reg #(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en_i,
  input  logic [NUM_IN-1:0] set_oh_i,
  input  logic              clr_en_i,
  input  logic [NUM_IN-1:0] clr_oh_i,
  output logic [NUM_IN-1:0] isr_q
);
  logic [NUM_IN-1:0] isr_nxt;

  always_comb begin
    isr_nxt = isr_q;
    if (clr_en_i) isr_nxt = isr_nxt & ~clr_oh_i;
    if (set_en_i) isr_nxt = isr_nxt | set_oh_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_nxt;
  end
endmodule

// File: rtl/irq_nest_resolver.sv
module irq_nest_resolver #(
  parameter int NUM_IN = 8,
  localparam int IDX_W = $clog2(NUM_IN + 1),
  localparam int ID_W  = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req_i,
  input  logic              mask_we_i,
  input  logic [NUM_IN-1:0] mask_wdata_i,
  input  logic              sfn_en_i,
  input  logic              aeoi_en_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              int_o,
  output logic              ack_valid_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic [NUM_IN-1:0] isr_o
);
  logic [NUM_IN-1:0] irr_q, mask_q, cand, win_oh, top_oh;
  logic [IDX_W-1:0]  win_idx, top_idx;
  logic              win_any, top_any;
  logic              outrank, ack_fire, isr_set, isr_clr;

  irq_req_stage #(.NUM_IN(NUM_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .clr_en_i(ack_fire), .clr_oh_i(win_oh),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .irr_q(irr_q), .mask_q(mask_q)
  );

  assign cand = irr_q & ~mask_q;

  irq_prio_enc #(.NUM_IN(NUM_IN)) u_win (
    .vec_i(cand), .any_o(win_any), .idx_o(win_idx), .onehot_o(win_oh)
  );

  irq_prio_enc #(.NUM_IN(NUM_IN)) u_top (
    .vec_i(isr_o), .any_o(top_any), .idx_o(top_idx), .onehot_o(top_oh)
  );

  // top_idx equals NUM_IN when nothing is in service, so any winner outranks it
  assign outrank  = win_any && ((win_idx < top_idx) || (sfn_en_i && (win_idx == top_idx)));
  assign ack_fire = ack_i && outrank;
  assign isr_set  = ack_fire && !aeoi_en_i;
  assign isr_clr  = eoi_i && top_any;

  irq_isr_reg #(.NUM_IN(NUM_IN)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .set_en_i(isr_set), .set_oh_i(win_oh),
    .clr_en_i(isr_clr), .clr_oh_i(top_oh),
    .isr_q(isr_o)
  );

  assign int_o       = outrank;
  assign ack_valid_o = ack_fire;
  assign ack_id_o    = win_idx[ID_W-1:0];
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int NUM_IN = 8,
  localparam int ID_W = $clog2(NUM_IN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfn_en_i,
  input logic              aeoi_en_i,
  input logic              ack_i,
  input logic              eoi_i,
  input logic              int_o,
  input logic              ack_valid_o,
  input logic [ID_W-1:0]   ack_id_o,
  input logic [NUM_IN-1:0] isr_o
);
  logic [NUM_IN-1:0] above_excl, above_incl;

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      above_excl[i] = (i < int'(ack_id_o));
      above_incl[i] = (i <= int'(ack_id_o));
    end
  end

  p_nested_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && !sfn_en_i) |-> ((isr_o & above_incl) == '0));

  p_special_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && sfn_en_i) |-> ((isr_o & above_excl) == '0));

  p_ack_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && !aeoi_en_i) |=> isr_o[$past(ack_id_o)]);

  p_ack_needs_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> (ack_i && int_o));

  p_ignored_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !eoi_i) |=> (isr_o == $past(isr_o)));

  p_auto_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && aeoi_en_i && !eoi_i) |=> (isr_o == $past(isr_o)));

  p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_valid_o) |=>
      ($countones(isr_o) == $countones($past(isr_o)) - (($past(isr_o) != '0) ? 1 : 0)));
endmodule

bind irq_nest_resolver irq_nest_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfn_en_i(sfn_en_i), .aeoi_en_i(aeoi_en_i),
  .ack_i(ack_i), .eoi_i(eoi_i), .int_o(int_o), .ack_valid_o(ack_valid_o),
  .ack_id_o(ack_id_o), .isr_o(isr_o)
);

// File: tb/test_irq_nest_resolver.sv
module test_irq_nest_resolver;
  localparam int CLK_P = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req, mask_wdata;
  logic mask_we, sfn, aeoi, ack, eoi;
  logic int_o, ack_valid_o;
  logic [2:0] ack_id_o;
  logic [N-1:0] isr_o;

  int vectors = 0;
  int fails = 0;
  string tag = "R1";

  logic [N-1:0] m_irr, m_isr, m_mask;

  always #(CLK_P/2) clk = ~clk;

  irq_nest_resolver #(.NUM_IN(N)) i_irq_nest_resolver (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_we_i(mask_we),
    .mask_wdata_i(mask_wdata), .sfn_en_i(sfn), .aeoi_en_i(aeoi),
    .ack_i(ack), .eoi_i(eoi), .int_o(int_o), .ack_valid_o(ack_valid_o),
    .ack_id_o(ack_id_o), .isr_o(isr_o)
  );

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return N;
  endfunction

  function automatic logic exp_int();
    int w, t;
    w = lowest(m_irr & ~m_mask);
    t = lowest(m_isr);
    return (w < N) && ((w < t) || (sfn && w == t));
  endfunction

  task automatic check(input string t, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic cyc();
    logic ei, fire;
    int w, t;
    logic [N-1:0] nisr, nirr;
    @(negedge clk);
    ei = exp_int();
    w  = lowest(m_irr & ~m_mask);
    t  = lowest(m_isr);
    check(tag, "int_o", int'(int_o), int'(ei));
    check(tag, "isr_o", int'(isr_o), int'(m_isr));
    check(tag, "ack_valid_o", int'(ack_valid_o), int'(ack && ei));
    if (ei) check(tag, "ack_id_o", int'(ack_id_o), w);
    @(posedge clk);
    fire = ack && ei;
    nisr = m_isr;
    if (eoi && t < N) nisr[t] = 1'b0;
    if (fire && !aeoi) nisr[w] = 1'b1;
    nirr = req;
    if (fire) nirr[w] = 1'b0;
    m_isr = nisr;
    m_irr = nirr;
    if (mask_we) m_mask = mask_wdata;
    #1;
  endtask

  task automatic serve(input int i);
    req = N'(1) << i; cyc();
    ack = 1'b1; cyc();
    ack = 1'b0; req = '0; cyc();
  endtask

  task automatic drain();
    string keep;
    keep = tag; tag = "R8";
    eoi = 1'b1;
    repeat (N) cyc();
    eoi = 1'b0;
    tag = keep;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual still running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; mask_we = 1'b0; mask_wdata = '0;
    sfn = 1'b0; aeoi = 1'b0; ack = 1'b0; eoi = 1'b0;
    m_irr = '0; m_isr = '0; m_mask = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    tag = "R1";
    @(negedge clk);
    check("R1", "int_o after reset", int'(int_o), 0);
    check("R1", "isr_o after reset", int'(isr_o), 0);
    @(posedge clk); #1;

    // R2, R4, R5: each input alone, in both policies
    for (int s = 0; s < 2; s++) begin
      sfn = s[0];
      for (int i = 0; i < N; i++) begin
        tag = "R2"; req = N'(1) << i; cyc(); cyc();
        check("R2", "int_o one cycle after request", int'(int_o), 1);
        tag = "R5"; ack = 1'b1; cyc();
        ack = 1'b0; req = '0; cyc();
        check("R5", "isr_o after acknowledge", int'(isr_o), 1 << i);
        tag = "R8"; eoi = 1'b1; cyc(); eoi = 1'b0;
        check("R8", "isr_o after end-of-interrupt", int'(isr_o), 0);
      end
    end
    sfn = 1'b0;

    // R4: every request pattern, fixed priority
    tag = "R4";
    for (int v = 1; v < 256; v++) begin
      req = N'(v); cyc(); cyc();
      check("R4", "ack_id_o priority", int'(ack_id_o), lowest(N'(v)));
      req = '0; cyc();
      tag = "R2"; cyc(); tag = "R4";
    end

    // R3: every mask value against all requests
    tag = "R3";
    for (int m = 0; m < 256; m++) begin
      mask_we = 1'b1; mask_wdata = N'(m); req = '1; cyc();
      mask_we = 1'b0; cyc();
      check("R3", "int_o under mask", int'(int_o), int'(m != 255));
      if (m != 255) check("R3", "ack_id_o under mask", int'(ack_id_o), lowest(~N'(m)));
      req = '0; cyc();
    end
    mask_we = 1'b1; mask_wdata = '0; cyc(); mask_we = 1'b0; cyc();

    // R6, R7, R12: in-service input against requesting input
    for (int s = 0; s < 2; s++) begin
      sfn = s[0];
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          tag = "R5"; serve(a);
          tag = (b < a) ? "R12" : (s == 1 ? "R7" : "R6");
          req = N'(1) << b; cyc(); cyc();
          check(tag, "int_o nesting", int'(int_o), int'((b < a) || (s == 1 && b == a)));
          req = '0; cyc(); cyc();
          drain();
        end
      end
    end
    sfn = 1'b0;

    // R8: stacked services retire highest priority first
    tag = "R5";
    serve(7); serve(3); serve(0);
    check("R8", "stacked isr_o", int'(isr_o), 'h89);
    tag = "R8";
    eoi = 1'b1; cyc(); check("R8", "isr_o after first eoi", int'(isr_o), 'h88);
    cyc(); check("R8", "isr_o after second eoi", int'(isr_o), 'h80);
    cyc(); check("R8", "isr_o after third eoi", int'(isr_o), 'h00);
    cyc(); check("R8", "isr_o eoi on empty", int'(isr_o), 'h00);
    eoi = 1'b0;

    // R9: automatic end-of-interrupt
    tag = "R9"; aeoi = 1'b1;
    serve(4);
    check("R9", "isr_o with auto eoi", int'(isr_o), 0);
    aeoi = 1'b0;

    // R10: acknowledge while int_o low
    tag = "R10";
    ack = 1'b1; cyc(); ack = 1'b0;
    check("R10", "isr_o after stray ack", int'(isr_o), 0);
    tag = "R5"; serve(2);
    tag = "R10"; req = N'(1) << 5; cyc();
    ack = 1'b1; cyc(); ack = 1'b0; req = '0; cyc();
    check("R10", "isr_o after blocked ack", int'(isr_o), 'h04);
    drain();

    // R11: acknowledge and end-of-interrupt together
    tag = "R5"; serve(5);
    tag = "R11"; req = N'(1) << 2; cyc();
    ack = 1'b1; eoi = 1'b1; cyc();
    ack = 1'b0; eoi = 1'b0; req = '0; cyc();
    check("R11", "isr_o after ack with eoi", int'(isr_o), 'h04);
    drain();

    // R1: reset in the middle of activity
    mask_we = 1'b1; mask_wdata = 8'hF0; cyc(); mask_we = 1'b0;
    tag = "R5"; serve(1);
    rst_n = 1'b0; @(posedge clk); #1; rst_n = 1'b1;
    m_irr = '0; m_isr = '0; m_mask = '0;
    tag = "R1";
    check("R1", "isr_o after mid-run reset", int'(isr_o), 0);
    req = N'(1) << 6; cyc(); cyc();
    check("R1", "masks cleared by reset", int'(int_o), 1);
    req = '0; cyc(); cyc();

    summary();
    $finish;
  end
endmodule